// File: doc/BRIEF.md
# 64-bit SECDED Read Checker

This block sits on the read return path of a flash array. Each read delivers a 64-bit data word and an 8-bit check byte stored beside it. The checker recomputes the check bits and compares them with the stored byte. It repairs any single flipped bit, whether that bit is in the data or in the check byte. It flags any pair of flipped bits, which it cannot repair.

Checking is always on for the information region. In the user region it is off unless an enable bit is set. When enabled, it covers only the span from a programmable start page up to the top of the user region. A word whose data and check bits are all ones is an erased location, and it is passed through unchecked. A separate encoder module computes check bytes with the same code. The corrected word and its two flags can be registered or left combinational, chosen by a parameter.

Top module: `secded_read_checker`

## Requirements
- R1: The check byte of data word d has bit i (i = 0..6) equal to the XOR of every data bit j whose code position has bit i set. The position of data bit j is the (j+1)-th integer, counting up from 5, that is not a power of two. Bit 7 is the XOR of all 64 data bits and check bits 0..6. The encoder maps all-zero data to 0x00, and maps all-ones data to a byte other than 0xFF.
- R2: A checked read whose check byte matches its data returns the data unchanged, with both flags at 0.
- R3: A checked read with exactly one flipped bit among the 72 stored bits returns the original 64-bit data, with outCorrected=1 and outDoubleErr=0.
- R4: A checked read with exactly two flipped bits returns the received data unaltered, with outDoubleErr=1 and outCorrected=0.
- R5: A read whose 64 data bits and 8 check bits are all ones returns all ones with both flags at 0, in any region and under any configuration.
- R6: A user-region read while eccCfg bit 0 is 0 returns the raw data with both flags at 0.
- R7: With eccCfg bit 0 set, a user-region read is checked only when start <= rdAddr <= USER_TOP. Here start is {eccCfg[31:8], 8'h00} rounded down to a PAGE_BYTES boundary. All other user-region reads return raw data with both flags at 0.
- R8: A read with infoSpace=1 is always checked, whatever eccCfg holds.
- R9: With REG_OUT=1, the outputs show the result for the inputs present at the previous rising clock edge. While rstN is low, all outputs are 0.
- R10: outCorrected and outDoubleErr are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Active-low asynchronous reset |
| rdAddr | input | 32 | Byte address of the read |
| rdData | input | 64 | Data word as read from the array |
| rdChk | input | 8 | Stored check byte |
| eccCfg | input | 32 | Bit 0 enables checking in the user region; bits [31:8] hold the start pointer |
| infoSpace | input | 1 | 1 when the read targets the information region |
| outData | output | 64 | Corrected or raw data |
| outCorrected | output | 1 | A single-bit error was repaired |
| outDoubleErr | output | 1 | An uncorrectable double-bit error was seen |

## Verification
Three data patterns are used: all zeros, all ones, and a mixed word. For each pattern the bench tries the clean codeword, every one of the 72 single-bit flips and every one of the 2556 flip pairs. The flips in the data bits and the flips in the check byte show whether the syndrome decode separates a data error, a check-bit error and an overall-parity error. The pairs show that no double error is mistaken for a repairable single error. Range tests use a single-bit error as the probe, placed just below the start page, at the page start and at USER_TOP, and at the first address past USER_TOP. Further probes use an unaligned start pointer, a disabled enable bit, the information flag and an erased word, and they show which reads are checked and which are passed raw.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W    = 64;
  localparam int CHK_W     = 8;
  localparam int SYN_W     = CHK_W - 1;
  localparam int FIRST_POS = 5;
  localparam int POS_LIMIT = 1 << SYN_W;

  typedef struct packed {
    logic fixEn;
    logic flagEn;
  } ctrl_t;

  // Code position of every data bit, packed SYN_W bits per entry.
  function automatic logic [DATA_W*SYN_W-1:0] buildPosTable();
    logic [DATA_W*SYN_W-1:0] tbl;
    int cnt;
    tbl = '0;
    cnt = 0;
    for (int p = FIRST_POS; p < POS_LIMIT; p++) begin
      if (((p & (p - 1)) != 0) && (cnt < DATA_W)) begin
        tbl[cnt*SYN_W +: SYN_W] = SYN_W'(p);
        cnt++;
      end
    end
    return tbl;
  endfunction

  localparam logic [DATA_W*SYN_W-1:0] POS_TBL = buildPosTable();

  function automatic logic [CHK_W-1:0] encodeCheck(logic [DATA_W-1:0] d);
    logic [SYN_W-1:0] p;
    p = '0;
    for (int j = 0; j < DATA_W; j++) begin
      for (int i = 0; i < SYN_W; i++) begin
        if (POS_TBL[j*SYN_W + i]) p[i] = p[i] ^ d[j];
      end
    end
    return {(^d) ^ (^p), p};
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  assign check = encodeCheck(data);
endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
  import secded_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              PAGE_BYTES = 2048,
  parameter logic [31:0]     USER_TOP   = 32'h0007_FFFF
) (
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdChk,
  input  logic [31:0]       eccCfg,
  input  logic              infoSpace,
  output ctrl_t             strobes
);
  localparam int              PTR_LSB   = 8;
  localparam logic [ADDR_W-1:0] PAGE_MASK = ~ADDR_W'(PAGE_BYTES - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(USER_TOP);

  logic [ADDR_W-1:0] startAddr;
  logic erased;
  logic inRange;
  logic checkOn;

  always_comb begin
    startAddr = {eccCfg[ADDR_W-1:PTR_LSB], {PTR_LSB{1'b0}}} & PAGE_MASK;
    erased    = (&rdData) & (&rdChk);
    inRange   = (rdAddr >= startAddr) && (rdAddr <= TOP_ADDR);
    checkOn   = !erased && (infoSpace || (eccCfg[0] && inRange));
    strobes.fixEn  = checkOn;
    strobes.flagEn = checkOn;
  end
endmodule

// File: rtl/secded_datapath.sv
module secded_datapath
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdChk,
  input  ctrl_t             strobes,
  output logic [DATA_W-1:0] fixedData,
  output logic              singleErr,
  output logic              doubleErr
);
  logic [CHK_W-1:0]  recomputed;
  logic [SYN_W-1:0]  syndrome;
  logic              parityOdd;
  logic [DATA_W-1:0] dataHit;
  logic              checkBitHit;
  logic              correctable;

  assign recomputed = encodeCheck(rdData);
  assign syndrome   = recomputed[SYN_W-1:0] ^ rdChk[SYN_W-1:0];
  assign parityOdd  = (^rdData) ^ (^rdChk);

  for (genvar j = 0; j < DATA_W; j++) begin : g_hit
    assign dataHit[j] = parityOdd && (syndrome == POS_TBL[j*SYN_W +: SYN_W]);
  end

  always_comb begin
    checkBitHit = parityOdd && ((syndrome == '0) || $onehot(syndrome));
    correctable = checkBitHit || (|dataHit);
    fixedData   = strobes.fixEn ? (rdData ^ dataHit) : rdData;
    singleErr   = strobes.flagEn && correctable;
    doubleErr   = strobes.flagEn && !correctable && (parityOdd || (syndrome != '0));
  end
endmodule

// File: rtl/secded_read_checker.sv
module secded_read_checker
  import secded_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          PAGE_BYTES = 2048,
  parameter logic [31:0] USER_TOP   = 32'h0007_FFFF,
  parameter bit          REG_OUT    = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] rdAddr,
  input  logic [63:0] rdData,
  input  logic [7:0]  rdChk,
  input  logic [31:0] eccCfg,
  input  logic        infoSpace,
  output logic [63:0] outData,
  output logic        outCorrected,
  output logic        outDoubleErr
);
  ctrl_t             strobes;
  logic [DATA_W-1:0] fixedData;
  logic              singleErr;
  logic              doubleErr;

  secded_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .USER_TOP(USER_TOP)
  ) u_ctrl (
    .rdAddr(rdAddr[ADDR_W-1:0]), .rdData(rdData), .rdChk(rdChk),
    .eccCfg(eccCfg), .infoSpace(infoSpace), .strobes(strobes)
  );

  secded_datapath u_dp (
    .rdData(rdData), .rdChk(rdChk), .strobes(strobes),
    .fixedData(fixedData), .singleErr(singleErr), .doubleErr(doubleErr)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outData      <= '0;
        outCorrected <= 1'b0;
        outDoubleErr <= 1'b0;
      end else begin
        outData      <= fixedData;
        outCorrected <= singleErr;
        outDoubleErr <= doubleErr;
      end
    end
  end else begin : g_comb
    assign outData      = rstN ? fixedData : '0;
    assign outCorrected = rstN && singleErr;
    assign outDoubleErr = rstN && doubleErr;
  end
endmodule

// File: rtl/secded_read_checker_sva.sv
module secded_read_checker_sva
  import secded_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] rdAddr,
  input logic [63:0] rdData,
  input logic [7:0]  rdChk,
  input logic [31:0] eccCfg,
  input logic        infoSpace,
  input logic [63:0] outData,
  input logic        outCorrected,
  input logic        outDoubleErr
);
  logic [63:0] dData;
  logic [7:0]  dChk;
  logic [31:0] dCfg;
  logic        dInfo;
  logic        seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      dData <= rdData;
      dChk  <= rdChk;
      dCfg  <= eccCfg;
      dInfo <= infoSpace;
    end
  end else begin : g_now
    assign dData = rdData;
    assign dChk  = rdChk;
    assign dCfg  = eccCfg;
    assign dInfo = infoSpace;
  end

  // R10
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outCorrected && outDoubleErr));

  // R5
  a_r5_erased_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (seen && (&dData) && (&dChk)) |-> (!outCorrected && !outDoubleErr && (&outData)));

  // R6
  a_r6_disabled_raw: assert property (@(posedge clk) disable iff (!rstN)
    (seen && !dInfo && !dCfg[0]) |-> (outData == dData && !outCorrected && !outDoubleErr));

  // R2
  a_r2_clean_word: assert property (@(posedge clk) disable iff (!rstN)
    (seen && dChk == encodeCheck(dData)) |-> (outData == dData && !outCorrected && !outDoubleErr));

  // R4
  a_r4_double_raw: assert property (@(posedge clk) disable iff (!rstN)
    (seen && outDoubleErr) |-> (outData == dData));
endmodule

bind secded_read_checker secded_read_checker_sva #(.REG_OUT(REG_OUT)) u_sva (.*);

// File: tb/secded_read_checker_tb.sv
module secded_read_checker_tb;
  localparam logic [31:0] TOP = 32'h0007_FFFF;
  localparam int          PG  = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] rdAddr = '0;
  logic [63:0] rdData = '0;
  logic [7:0]  rdChk = '0;
  logic [31:0] eccCfg = '0;
  logic        infoSpace = 1'b0;
  logic [63:0] outData;
  logic        outCorrected;
  logic        outDoubleErr;
  logic [63:0] encIn = '0;
  logic [7:0]  encOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  secded_read_checker #(.PAGE_BYTES(PG), .USER_TOP(TOP), .REG_OUT(1'b1)) u_dut (.*);
  secded_encoder u_enc (.data(encIn), .check(encOut));

  function automatic int refPos(int j);
    int cnt = 0;
    int res = 0;
    for (int p = 5; p < 128; p++) begin
      if ($countones(p) != 1) begin
        if (cnt == j) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [7:0] refCheck(logic [63:0] d);
    logic [7:0] c = '0;
    for (int j = 0; j < 64; j++) begin
      int p = refPos(j);
      for (int i = 0; i < 7; i++) if ((p >> i) & 1) c[i] ^= d[j];
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(string tag, logic [63:0] expD, logic expC, logic expE);
    checks++;
    if (outData !== expD || outCorrected !== expC || outDoubleErr !== expE) begin
      errors++;
      $display("FAIL %s: got data=%h corr=%b dbl=%b expected data=%h corr=%b dbl=%b",
               tag, outData, outCorrected, outDoubleErr, expD, expC, expE);
    end
  endtask

  task automatic apply(logic [31:0] a, logic [63:0] d, logic [7:0] c, logic [31:0] cfg, logic info);
    rdAddr = a; rdData = d; rdChk = c; eccCfg = cfg; infoSpace = info;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(logic [63:0] pat);
    logic [71:0] good = {refCheck(pat), pat};
    apply(32'h0, pat, good[71:64], 32'h0, 1'b1);
    check("R2 clean", pat, 1'b0, 1'b0);
    for (int k = 0; k < 72; k++) begin
      logic [71:0] bad = good ^ (72'd1 << k);
      apply(32'h0, bad[63:0], bad[71:64], 32'h0, 1'b1);
      check("R3 single", pat, 1'b1, 1'b0);
    end
    for (int a = 0; a < 72; a++) begin
      for (int b = a + 1; b < 72; b++) begin
        logic [71:0] bad = good ^ (72'd1 << a) ^ (72'd1 << b);
        apply(32'h0, bad[63:0], bad[71:64], 32'h0, 1'b1);
        check("R4 double", bad[63:0], 1'b0, 1'b1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] mix = 64'hA5C3_0F96_1E2D_784B;
    logic [7:0]  mixC;
    logic [63:0] mixBad;
    logic [31:0] startA;
    @(negedge clk);
    rdData = '1; rdChk = 8'h5A; infoSpace = 1'b1;
    @(negedge clk);
    check("R9 reset", 64'h0, 1'b0, 1'b0);
    rstN = 1'b1;

    // R1 encoder
    foreach (mix[i]) begin end
    encIn = '0; #1;
    checks++; if (encOut !== 8'h00) begin errors++; $display("FAIL R1 zero: got %h expected 00", encOut); end
    encIn = '1; #1;
    checks++; if (encOut !== refCheck('1) || encOut == 8'hFF) begin errors++; $display("FAIL R1 ones: got %h expected %h", encOut, refCheck('1)); end
    encIn = mix; #1;
    checks++; if (encOut !== refCheck(mix)) begin errors++; $display("FAIL R1 mix: got %h expected %h", encOut, refCheck(mix)); end
    @(negedge clk);

    // R9 latency: result after one edge
    mixC = refCheck(mix);
    mixBad = mix ^ 64'h10;
    apply(32'h0, mixBad, mixC, 32'h0, 1'b1);
    check("R9 latency", mix, 1'b1, 1'b0);

    sweep(64'h0);
    sweep('1);
    sweep(mix);

    // R5 erased bypass
    apply(32'h0, '1, 8'hFF, 32'h0, 1'b1);
    check("R5 erased info", '1, 1'b0, 1'b0);
    apply(32'h0004_0000, '1, 8'hFF, 32'h1, 1'b0);
    check("R5 erased user", '1, 1'b0, 1'b0);

    // R6 disabled user region
    apply(32'h0004_0000, mixBad, mixC, 32'h0, 1'b0);
    check("R6 disabled", mixBad, 1'b0, 1'b0);

    // R8 info region ignores enable
    apply(32'h0009_0000, mixBad, mixC, 32'h0, 1'b1);
    check("R8 info", mix, 1'b1, 1'b0);

    // R7 range with start page 0x0004_0000
    startA = 32'h0004_0000;
    apply(startA - 1, mixBad, mixC, startA | 32'h1, 1'b0);
    check("R7 below start", mixBad, 1'b0, 1'b0);
    apply(startA, mixBad, mixC, startA | 32'h1, 1'b0);
    check("R7 at start", mix, 1'b1, 1'b0);
    apply(TOP, mixBad, mixC, startA | 32'h1, 1'b0);
    check("R7 at top", mix, 1'b1, 1'b0);
    apply(TOP + 1, mixBad, mixC, startA | 32'h1, 1'b0);
    check("R7 above top", mixBad, 1'b0, 1'b0);
    // unaligned pointer rounds down to its page
    apply(startA, mixBad, mixC, (startA + 32'h0000_0300) | 32'h1, 1'b0);
    check("R7 rounded start", mix, 1'b1, 1'b0);
    apply(startA - 1, mixBad, mixC, (startA + 32'h0000_0300) | 32'h1, 1'b0);
    check("R7 rounded below", mixBad, 1'b0, 1'b0);

    // R10 sampled explicitly on a double error
    apply(32'h0, mix ^ 64'h3, mixC, 32'h0, 1'b1);
    checks++;
    if (outCorrected && outDoubleErr) begin errors++; $display("FAIL R10: got both flags expected one"); end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule